// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 SDRAM interface. It takes the memory from power-up to the point where ordinary traffic may begin. After a start request it holds the clock enable low for a fixed settling time and then raises it. It then issues the mandatory series of precharge, mode register, extended mode register and refresh commands, leaving at least the configured number of controller cycles after each one. It finally waits for the memory's delay-locked loop to lock and then raises a done flag.

The configuration is captured once, when the start request is accepted. It covers CAS latency, additive latency, burst length, burst type, write recovery, and the cycle counts for the precharge, mode-register and refresh recovery times. Every register write is built from this captured configuration as a complete word. The command, bank and address outputs are registered, so the memory samples them on the next rising clock edge.

Top module: `ddr2_init_seq`

## Requirements
- R1: While the synchronous active-low reset is asserted, and on the cycle after it, the outputs are as follows: CKE low, ODT low, done low, command code NOP (4'b0111 on {CS#,RAS#,CAS#,WE#}), and bank and address zero.
- R2: A start request accepted in the idle state keeps CKE low for exactly PWR_CYC = ceil(POWERUP_NS*1000/CLK_PERIOD_PS) cycles, counted from the first cycle after acceptance (50 cycles at the defaults). CKE then rises, and the first command follows one cycle later. No command other than NOP is driven while CKE is low.
- R3: Commands come in this fixed order: precharge-all (4'b0010, A10=1), EMR1 write (4'b0000, bank 01), MR write (bank 00), precharge-all, refresh (4'b0001), refresh, MR write, EMR1 write, EMR1 write. Precharge-all and refresh commands drive bank 00.
- R4: The gap from each command to the next is exactly the configured count: tRP after a precharge-all, tRFC after a refresh, tMRD after a register write. A configured count of 0 acts as 1.
- R5: MR words carry the burst length in A2:A0 (010 for 4, 011 for 8), the burst type in A3 (1 = interleaved), the CAS latency in A6:A4 and write recovery minus one in A11:A9. A8 (DLL reset) is 1 in the first MR write and 0 in the second. All other bits are 0.
- R6: EMR1 words carry the additive latency in A5:A3, with A0=0 to enable the DLL. In the second EMR1 write (OCD default), A9:A7 are 111. In the first and the last, A9:A7 are 000. All other bits are 0 in all three.
- R7: Done rises at the later of two points: the last EMR1 write plus tMRD, or the DLL-reset MR write plus 200 cycles.
- R8: ODT stays low at all times.
- R9: Once done is high it stays high until reset, with CKE high and only NOP driven.
- R10: Start requests are ignored while the sequence is running or finished.
- R11: Configuration inputs are captured when start is accepted. Later changes to them do not alter the commands issued.
- R12: A reset in the middle of the sequence returns the block to idle. CKE stays low until a new start request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, same frequency as the memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to begin initialization |
| cfg_cl_i | input | 3 | CAS latency, 3 to 7 |
| cfg_al_i | input | 3 | Additive latency, 0 to 6 |
| cfg_bl8_i | input | 1 | 1 = burst length 8, 0 = burst length 4 |
| cfg_interleave_i | input | 1 | 1 = interleaved burst order, 0 = sequential |
| cfg_wr_i | input | 4 | Write recovery in cycles, 2 to 8 |
| cfg_trp_i | input | TIM_W | Precharge recovery in cycles |
| cfg_tmrd_i | input | TIM_W | Register-write recovery in cycles |
| cfg_trfc_i | input | TIM_W | Refresh recovery in cycles |
| cke_o | output | 1 | Clock enable to the memory |
| odt_o | output | 1 | On-die termination control, held low |
| cmd_o | output | 4 | {CS#, RAS#, CAS#, WE#} command code |
| ba_o | output | 2 | Bank address / register select |
| addr_o | output | ADDR_W | Address bus / register word |
| done_o | output | 1 | Memory ready for normal operation |

## Verification
Four configurations exercise the main sequence. In one, the DLL lock wait sets the done time. In another, a long refresh time pushes the last register write past the lock point, so the tMRD wait sets it instead. A third uses counts of 1, which places commands in back-to-back cycles. A fourth uses counts of 0, which must behave as 1. The configurations differ in every mode field, so a swapped or misplaced bit field shows up in the register words. Separate runs change the configuration and pulse start in the middle of a sequence, pulse start after done, and apply reset part-way through, to separate captured state from live inputs.

// File: rtl/ddr2_init_pkg.sv
`timescale 1ns/1ps
// Package: shared types and command codes for the DDR2 initialization sequencer.
// Assumes a single-rank x16 device whose mode words fit in 13 address bits.
package ddr2_init_pkg;

    // Sequencer steps; the command states also select what the generator drives.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PWR,
        ST_PRE1,
        ST_EMR_DLL,
        ST_MR_RST,
        ST_PRE2,
        ST_REF1,
        ST_REF2,
        ST_MR_RUN,
        ST_EMR_OCDD,
        ST_EMR_OCDX,
        ST_LOCK,
        ST_READY
    } step_e;

    // Command codes on {CS#, RAS#, CAS#, WE#}.
    localparam logic [3:0] CMD_NOP  = 4'b0111;
    localparam logic [3:0] CMD_PREA = 4'b0010;
    localparam logic [3:0] CMD_REF  = 4'b0001;
    localparam logic [3:0] CMD_MRW  = 4'b0000;

    // Register selects on the bank pins.
    localparam logic [1:0] SEL_MR   = 2'b00;
    localparam logic [1:0] SEL_EMR1 = 2'b01;

    // Mode fields captured at start.
    typedef struct packed {
        logic [2:0] cl;
        logic [2:0] al;
        logic       bl8;
        logic       interleave;
        logic [3:0] wr;
    } mode_cfg_t;

endpackage

// File: rtl/ddr2_init_timer.sv
`timescale 1ns/1ps
// Module: loadable down-counter that reports when it has reached zero.
// Assumes load takes precedence; the count stops at zero.
module ddr2_init_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    // Reload on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    // Zero flag for the sequencer.
    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/ddr2_init_cmdgen.sv
`timescale 1ns/1ps
// Module: combinational command, bank and address word for a sequencer step.
// Assumes ADDR_W >= 13; each register word is built whole from the captured
// configuration, with unused and reserved bits at zero.
module ddr2_init_cmdgen
    import ddr2_init_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  step_e             step_i,
    input  mode_cfg_t         cfg_i,
    output logic [3:0]        cmd_o,
    output logic [1:0]        ba_o,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] mr_word;
    logic [ADDR_W-1:0] emr_word;
    logic [3:0]        wr_m1;

    // Base MR word: burst length, burst type, CAS latency, write recovery.
    always_comb begin
        wr_m1          = cfg_i.wr - 4'd1;
        mr_word        = '0;
        mr_word[2:0]   = cfg_i.bl8 ? 3'b011 : 3'b010;
        mr_word[3]     = cfg_i.interleave;
        mr_word[6:4]   = cfg_i.cl;
        mr_word[11:9]  = wr_m1[2:0];
    end

    // Base EMR1 word: DLL enabled (A0=0), additive latency, OCD bits clear.
    always_comb begin
        emr_word      = '0;
        emr_word[5:3] = cfg_i.al;
    end

    // Select the command and word for the current step.
    always_comb begin
        cmd_o  = CMD_NOP;
        ba_o   = SEL_MR;
        addr_o = '0;
        unique case (step_i)
            ST_PRE1, ST_PRE2: begin
                cmd_o      = CMD_PREA;
                addr_o[10] = 1'b1;
            end
            ST_EMR_DLL, ST_EMR_OCDX: begin
                cmd_o  = CMD_MRW;
                ba_o   = SEL_EMR1;
                addr_o = emr_word;
            end
            ST_EMR_OCDD: begin
                cmd_o       = CMD_MRW;
                ba_o        = SEL_EMR1;
                addr_o      = emr_word;
                addr_o[9:7] = 3'b111;
            end
            ST_MR_RST: begin
                cmd_o     = CMD_MRW;
                addr_o    = mr_word;
                addr_o[8] = 1'b1;
            end
            ST_MR_RUN: begin
                cmd_o  = CMD_MRW;
                addr_o = mr_word;
            end
            ST_REF1, ST_REF2: begin
                cmd_o = CMD_REF;
            end
            default: begin
                cmd_o = CMD_NOP;
            end
        endcase
    end

endmodule

// File: rtl/ddr2_init_seq.sv
`timescale 1ns/1ps
// Module: DDR2 power-up initialization sequencer (top).
// Holds CKE low for the power-up time, then issues the fixed command series,
// waiting the configured count after each. It then waits for DLL lock and
// raises done. Assumes the controller clock equals the memory clock and that
// the configuration is legal when start is asserted.
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 8000,
    parameter int POWERUP_NS    = 400,
    parameter int DLL_LOCK_CYC  = 200,
    parameter int TIM_W         = 8,
    parameter int ADDR_W        = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        cfg_cl_i,
    input  logic [2:0]        cfg_al_i,
    input  logic              cfg_bl8_i,
    input  logic              cfg_interleave_i,
    input  logic [3:0]        cfg_wr_i,
    input  logic [TIM_W-1:0]  cfg_trp_i,
    input  logic [TIM_W-1:0]  cfg_tmrd_i,
    input  logic [TIM_W-1:0]  cfg_trfc_i,
    output logic              cke_o,
    output logic              odt_o,
    output logic [3:0]        cmd_o,
    output logic [1:0]        ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o
);

    localparam int PWR_CYC  = (POWERUP_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int TIM_MAX  = (1 << TIM_W);
    localparam int CNT_MAX  = (PWR_CYC > TIM_MAX) ? PWR_CYC : TIM_MAX;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);
    localparam int LOCK_W   = $clog2(DLL_LOCK_CYC + 1);
    localparam logic [CNT_W-1:0]  PWR_LOAD  = CNT_W'(PWR_CYC - 1);
    localparam logic [LOCK_W-1:0] LOCK_LOAD = LOCK_W'(DLL_LOCK_CYC - 1);

    step_e             state_q, state_d;
    mode_cfg_t         mcfg_q;
    logic [TIM_W-1:0]  trp_q, tmrd_q, trfc_q;
    logic              cke_q, cke_d;
    logic              done_q, done_d;
    logic              issue;
    logic              tmr_load, tmr_zero;
    logic [CNT_W-1:0]  tmr_val;
    logic              lock_load, lock_zero;
    logic [3:0]        gen_cmd;
    logic [1:0]        gen_ba;
    logic [ADDR_W-1:0] gen_addr;
    logic [3:0]        cmd_q;
    logic [1:0]        ba_q;
    logic [ADDR_W-1:0] addr_q;

    // Convert a configured count to a reload value; a count of 0 acts as 1.
    function automatic logic [CNT_W-1:0] reload_of(input logic [TIM_W-1:0] t);
        logic [CNT_W-1:0] ext;
        ext = CNT_W'(t);
        return (t == '0) ? '0 : (ext - CNT_W'(1));
    endfunction

    // Step that follows each command step.
    function automatic step_e next_of(input step_e s);
        case (s)
            ST_PRE1:     return ST_EMR_DLL;
            ST_EMR_DLL:  return ST_MR_RST;
            ST_MR_RST:   return ST_PRE2;
            ST_PRE2:     return ST_REF1;
            ST_REF1:     return ST_REF2;
            ST_REF2:     return ST_MR_RUN;
            ST_MR_RUN:   return ST_EMR_OCDD;
            ST_EMR_OCDD: return ST_EMR_OCDX;
            default:     return ST_LOCK;
        endcase
    endfunction

    // Recovery count that applies after each command step.
    function automatic logic [TIM_W-1:0] wait_of(input step_e s,
                                                 input logic [TIM_W-1:0] trp,
                                                 input logic [TIM_W-1:0] tmrd,
                                                 input logic [TIM_W-1:0] trfc);
        case (s)
            ST_PRE1, ST_PRE2: return trp;
            ST_REF1, ST_REF2: return trfc;
            default:          return tmrd;
        endcase
    endfunction

    // Wait timer shared by the power-up hold and every command gap.
    ddr2_init_timer #(.W(CNT_W)) i_wait_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    // DLL lock tracker started by the DLL-reset write.
    ddr2_init_timer #(.W(LOCK_W)) i_lock_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (lock_load),
        .load_val_i (LOCK_LOAD),
        .zero_o     (lock_zero)
    );

    // Command word for the current step.
    ddr2_init_cmdgen #(.ADDR_W(ADDR_W)) i_cmdgen (
        .step_i (state_q),
        .cfg_i  (mcfg_q),
        .cmd_o  (gen_cmd),
        .ba_o   (gen_ba),
        .addr_o (gen_addr)
    );

    // Next-state, timer reload and command issue decisions.
    always_comb begin
        state_d   = state_q;
        cke_d     = cke_q;
        done_d    = done_q;
        issue     = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        lock_load = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d  = ST_PWR;
                    tmr_load = 1'b1;
                    tmr_val  = PWR_LOAD;
                end
            end
            ST_PWR: begin
                if (tmr_zero) begin
                    cke_d   = 1'b1;
                    state_d = ST_PRE1;
                end
            end
            ST_LOCK: begin
                if (tmr_zero && lock_zero) begin
                    done_d  = 1'b1;
                    state_d = ST_READY;
                end
            end
            ST_READY: begin
                state_d = ST_READY;
            end
            default: begin
                if (tmr_zero) begin
                    issue     = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = reload_of(wait_of(state_q, trp_q, tmrd_q, trfc_q));
                    lock_load = (state_q == ST_MR_RST);
                    state_d   = next_of(state_q);
                end
            end
        endcase
    end

    // State, CKE and done registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cke_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cke_q   <= cke_d;
            done_q  <= done_d;
        end
    end

    // Capture the configuration when a start request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcfg_q <= '0;
            trp_q  <= '0;
            tmrd_q <= '0;
            trfc_q <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            mcfg_q <= '{cl: cfg_cl_i, al: cfg_al_i, bl8: cfg_bl8_i,
                        interleave: cfg_interleave_i, wr: cfg_wr_i};
            trp_q  <= cfg_trp_i;
            tmrd_q <= cfg_tmrd_i;
            trfc_q <= cfg_trfc_i;
        end
    end

    // Registered command bus: the issued command for one cycle, otherwise NOP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_NOP;
            ba_q   <= '0;
            addr_q <= '0;
        end else if (issue) begin
            cmd_q  <= gen_cmd;
            ba_q   <= gen_ba;
            addr_q <= gen_addr;
        end else begin
            cmd_q  <= CMD_NOP;
            ba_q   <= '0;
            addr_q <= '0;
        end
    end

    assign cke_o  = cke_q;
    assign odt_o  = 1'b0;
    assign cmd_o  = cmd_q;
    assign ba_o   = ba_q;
    assign addr_o = addr_q;
    assign done_o = done_q;

endmodule

// File: rtl/ddr2_init_chk.sv
`timescale 1ns/1ps
// Module: protocol checker for the initialization sequencer, bound to the top.
// Assumes the synchronous active-low reset of the sequencer.
module ddr2_init_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cke,
    input logic       odt,
    input logic       done,
    input logic [3:0] cmd
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!cke && !done && cmd == 4'b0111));

    // R8
    odt_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !odt);

    // R2
    no_cmd_cke_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != 4'b0111) |-> cke);

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R9
    ready_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cmd == 4'b0111 && cke));

    // R12
    cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

endmodule

bind ddr2_init_seq ddr2_init_chk i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cke   (cke_o),
    .odt   (odt_o),
    .done  (done_o),
    .cmd   (cmd_o)
);

// File: tb/test_ddr2_init_seq.sv
`timescale 1ns/1ps
module test_ddr2_init_seq;

    localparam int PWR   = 50;    // 400 ns at 8 ns
    localparam int LOCK  = 200;
    localparam int NVEC  = 4;
    // {cl[3], al[3], bl8, il, wr[4], trp[8], tmrd[8], trfc[8]}
    localparam logic [35:0] VECS [NVEC] = '{
        {3'd3, 3'd0, 1'b0, 1'b0, 4'd2, 8'd3, 8'd2, 8'd20},
        {3'd7, 3'd6, 1'b1, 1'b1, 4'd8, 8'd5, 8'd4, 8'd120},
        {3'd5, 3'd3, 1'b1, 1'b0, 4'd6, 8'd1, 8'd1, 8'd1},
        {3'd4, 3'd2, 1'b0, 1'b1, 4'd4, 8'd0, 8'd0, 8'd9}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  cl = '0, al = '0;
    logic        bl8 = 1'b0, il = 1'b0;
    logic [3:0]  wr = 4'd2;
    logic [7:0]  trp = '0, tmrd = '0, trfc = '0;
    logic        cke, odt, done;
    logic [3:0]  cmd;
    logic [1:0]  ba;
    logic [12:0] addr;

    int n_run = 0, n_fail = 0, cyc = 0;
    int ncmd, cke_cyc, done_cyc, odt_bad, lowcmd, t0;
    int         c_cyc [16];
    logic [3:0] c_cmd [16];
    logic [1:0] c_ba  [16];
    logic [12:0] c_adr [16];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ddr2_init_seq i_ddr2_init_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .cfg_cl_i(cl), .cfg_al_i(al), .cfg_bl8_i(bl8), .cfg_interleave_i(il),
        .cfg_wr_i(wr), .cfg_trp_i(trp), .cfg_tmrd_i(tmrd), .cfg_trfc_i(trfc),
        .cke_o(cke), .odt_o(odt), .cmd_o(cmd), .ba_o(ba), .addr_o(addr),
        .done_o(done)
    );

    // Monitor: log commands and first CKE / done cycles.
    always @(negedge clk) begin
        if (cmd != 4'b0111) begin
            if (ncmd < 16) begin
                c_cyc[ncmd] = cyc; c_cmd[ncmd] = cmd;
                c_ba[ncmd] = ba;   c_adr[ncmd] = addr;
            end
            ncmd = ncmd + 1;
            if (!cke) lowcmd = lowcmd + 1;
        end
        if (cke && cke_cyc < 0) cke_cyc = cyc;
        if (done && done_cyc < 0) done_cyc = cyc;
        if (odt) odt_bad = odt_bad + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic mon_clear();
        ncmd = 0; cke_cyc = -1; done_cyc = -1; odt_bad = 0; lowcmd = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk); rst_n = 1'b1;
        mon_clear();
    endtask

    task automatic drive_cfg(input logic [35:0] v);
        cl = v[35:33]; al = v[32:30]; bl8 = v[29]; il = v[28]; wr = v[27:24];
        trp = v[23:16]; tmrd = v[15:8]; trfc = v[7:0];
    endtask

    function automatic int eff(input logic [7:0] t);
        return (t == 0) ? 1 : int'(t);
    endfunction

    function automatic logic [12:0] mrw(input logic [35:0] v, input bit dllrst);
        logic [3:0] w1;
        w1 = v[27:24] - 4'd1;
        return {1'b0, w1[2:0], dllrst, 1'b0, v[35:33], v[28], (v[29] ? 3'b011 : 3'b010)};
    endfunction

    function automatic logic [12:0] emrw(input logic [35:0] v, input bit ocd);
        return {3'b000, (ocd ? 3'b111 : 3'b000), 1'b0, v[32:30], 3'b000};
    endfunction

    // Start with v; mode 1 scrambles config and re-pulses start mid-run.
    task automatic run_seq(input logic [35:0] v, input int mode);
        int k;
        drive_cfg(v);
        @(negedge clk); start = 1'b1; t0 = cyc + 1;
        @(negedge clk); start = 1'b0;
        if (mode == 1) begin
            repeat (70) @(negedge clk);
            drive_cfg(~v);
            start = 1'b1;
            repeat (3) @(negedge clk);
            start = 1'b0;
        end
        k = 0;
        while (done_cyc < 0 && k < 3000) begin @(negedge clk); k++; end
        chk(done_cyc >= 0, "R7 done timeout", done_cyc, 1);
    endtask

    // Compare the logged run against values derived from v.
    task automatic check_run(input logic [35:0] v, input string tag);
        logic [3:0]  ec [9];
        logic [1:0]  eb [9];
        logic [12:0] ea [9];
        int          ew [9];
        int          edone;
        ec = '{4'b0010, 4'b0000, 4'b0000, 4'b0010, 4'b0001, 4'b0001, 4'b0000, 4'b0000, 4'b0000};
        eb = '{2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd1};
        ea = '{13'h400, emrw(v, 0), mrw(v, 1), 13'h400, 13'h0, 13'h0, mrw(v, 0),
               emrw(v, 1), emrw(v, 0)};
        ew = '{eff(v[23:16]), eff(v[15:8]), eff(v[15:8]), eff(v[23:16]), eff(v[7:0]),
               eff(v[7:0]), eff(v[15:8]), eff(v[15:8]), eff(v[15:8])};
        $display("[TB] checking %s", tag);
        chk(cke_cyc - t0 == PWR, "R2 CKE low time", cke_cyc - t0, PWR);
        chk(lowcmd == 0, "R2 command with CKE low", lowcmd, 0);
        chk(ncmd == 9, "R3 command count", ncmd, 9);
        if (ncmd >= 9) begin
            chk(c_cyc[0] == cke_cyc + 1, "R2 first PREA after CKE", c_cyc[0], cke_cyc + 1);
            for (int i = 0; i < 9; i++) begin
                chk(c_cmd[i] == ec[i] && c_ba[i] == eb[i], "R3 command/bank",
                    {c_cmd[i], c_ba[i]}, {ec[i], eb[i]});
                if (i == 2 || i == 6)
                    chk(c_adr[i] == ea[i], "R5 MR word", c_adr[i], ea[i]);
                else if (i == 1 || i == 7 || i == 8)
                    chk(c_adr[i] == ea[i], "R6 EMR1 word", c_adr[i], ea[i]);
                else
                    chk(c_adr[i] == ea[i], "R3 address", c_adr[i], ea[i]);
                if (i < 8)
                    chk(c_cyc[i+1] - c_cyc[i] == ew[i], "R4 gap",
                        c_cyc[i+1] - c_cyc[i], ew[i]);
            end
            edone = c_cyc[8] + ew[8];
            if (c_cyc[2] + LOCK > edone) edone = c_cyc[2] + LOCK;
            chk(done_cyc == edone, "R7 done cycle", done_cyc, edone);
        end
        chk(odt_bad == 0, "R8 ODT high", odt_bad, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        mon_clear();
        repeat (2) @(negedge clk);
        // R1: outputs during reset
        chk(!cke && !done && !odt && cmd == 4'b0111 && ba == 0 && addr == 0,
            "R1 reset state", {cke, done, cmd}, {2'b00, 4'b0111});

        // Table-driven main sequence
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            run_seq(VECS[i], 0);
            check_run(VECS[i], "vector");
        end

        // R10 R11: mid-run start pulses and config changes ignored
        do_reset();
        run_seq(VECS[1], 1);
        check_run(VECS[1], "R10/R11 mid-run");

        // R9 R10: start after done is ignored; done and CKE held
        start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        chk(ncmd == 9, "R10 start after done", ncmd, 9);
        chk(done && cke && cmd == 4'b0111, "R9 ready hold", {done, cke, cmd}, {2'b11, 4'b0111});

        // R12: reset mid-sequence
        do_reset();
        drive_cfg(VECS[0]);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (100) @(negedge clk);
        chk(cke == 1'b1, "R12 precondition CKE high", cke, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!cke && !done && cmd == 4'b0111 && addr == 0, "R12 reset mid-run",
            {cke, done, cmd}, {2'b00, 4'b0111});
        rst_n = 1'b1;
        mon_clear();
        repeat (80) @(negedge clk);
        chk(!cke && ncmd == 0 && !done, "R12 stays idle", {cke, done, 8'(ncmd)}, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule